// File: doc/BRIEF.md
# Host-Side Slave Port with Mailbox Buffers

This block lets an external 8-bit master talk to an embedded engine through a pair of one-byte mailboxes and a status byte. The master drives chip select, read and write strobes and an address bit that chooses data or command. A master write fills the inbound mailbox and records in the status byte whether the byte was a command. A master read returns either the outbound mailbox or the status byte.

The engine sees the other side of the block. It drains the inbound mailbox, loads the outbound mailbox, writes the upper status nibble and toggles a spare flag. It can also switch two port pins from plain latch outputs to buffer-state signals, so the master can be interrupted.

The master strobes are asynchronous. Each strobe passes through a two-stage synchronizer, and the mailbox and flag updates fire on its trailing (rising) edge.

Top module: `hbi_slave_port`

## Requirements
- R1: After reset the status byte reads 0x00, the bus output enable is low and the two flag pins copy the port latch bits.
- R2: A master write with the address bit at 0 stores the byte in the inbound mailbox, sets status bit 1 (inbound full) and clears status bit 3 (command marker).
- R3: A master write with the address bit at 1 stores the byte in the inbound mailbox, sets status bit 1 and sets status bit 3.
- R4: A master read with the address bit at 0 returns the outbound mailbox and then clears status bit 0 (outbound full). With the address bit at 1 it returns the status byte and changes no flag.
- R5: Status bits 0, 1 and 3 do not change while a strobe is low. They change only after the strobe's rising edge has passed the synchronizer.
- R6: A local drain pulse clears status bit 1. A local load pulse stores the outbound byte and sets status bit 0. The inbound byte is always visible on the local read port.
- R7: A local status load copies its 4-bit value into status bits 7..4 and leaves bits 3..0 unchanged.
- R8: A local toggle pulse inverts status bit 2.
- R9: Before flag mode is enabled, pin 0 and pin 1 copy the latch bits. After the enable pulse, pin 0 is latch bit 0 AND outbound-full, and pin 1 is latch bit 1 AND NOT inbound-full.
- R10: With chip select high, strobes have no effect and the bus output enable stays low. The enable is high only while chip select and read are both low.
- R11: When a master write and a local drain land in the same cycle, inbound-full ends set. When a local load and a master read clear land in the same cycle, outbound-full ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_cs_n | input | 1 | Master chip select, active low |
| hst_rd_n | input | 1 | Master read strobe, active low |
| hst_wr_n | input | 1 | Master write strobe, active low |
| hst_a0 | input | 1 | Address bit: 0 data, 1 command/status |
| hst_din | input | 8 | Master write data |
| hst_dout | output | 8 | Master read data |
| hst_dout_oe | output | 1 | Drive enable for the master data bus |
| loc_in_rd | input | 1 | Local pulse: inbound mailbox consumed |
| loc_in_data | output | 8 | Inbound mailbox contents |
| loc_out_ld | input | 1 | Local pulse: load outbound mailbox |
| loc_out_data | input | 8 | Byte for the outbound mailbox |
| loc_sts_ld | input | 1 | Local pulse: load the upper status nibble |
| loc_sts_nib | input | 4 | Value for status bits 7..4 |
| loc_f0_tgl | input | 1 | Local pulse: invert status bit 2 |
| loc_flag_en | input | 1 | Local pulse: enter flag mode |
| loc_pin_latch | input | 2 | Port latch bits for the two flag pins |
| status | output | 8 | Status byte as the master sees it |
| irq_pins | output | 2 | Flag pins (bit 0 outbound, bit 1 inbound) |

## Verification
The hardest case to reach is a master-side flag update and a local-side update landing in the same clock. The master event fires only after two synchronizer stages and an edge detector. The bench therefore counts clock edges from the rising strobe and raises the local drain pulse in exactly the cycle the write event is live. It then checks that inbound-full stays set. It also samples status while a strobe is still low, so that any update on the falling edge is caught.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  // Low status nibble, packed in the order the master decodes it.
  typedef struct packed {
    logic cmd;       // bit 3: last master write was a command
    logic usr;       // bit 2: engine-owned spare flag
    logic in_full;   // bit 1: inbound mailbox holds unread byte
    logic out_full;  // bit 0: outbound mailbox holds unread byte
  } hbi_flags_t;

  // Flag pin drive: plain latch in port mode, gated buffer state in flag mode.
  function automatic logic [1:0] hbi_pin_out(input logic       mode,
                                             input logic [1:0] latch,
                                             input logic       in_full,
                                             input logic       out_full);
    if (!mode) return latch;
    return {latch[1] & ~in_full, latch[0] & out_full};
  endfunction

  // Master read mux: address bit high selects status.
  function automatic logic [7:0] hbi_read_mux(input logic       sel_status,
                                              input logic [7:0] sts,
                                              input logic [7:0] obuf);
    return sel_status ? sts : obuf;
  endfunction

endpackage

// File: rtl/hbi_strobe_sync.sv
module hbi_strobe_sync #(
  parameter int          W       = 2,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     stage[s] <= RST_VAL;
        else if (s == 0) stage[s] <= d_in;
        else            stage[s] <= stage[(s > 0) ? s-1 : 0];
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/hbi_regs.sv
module hbi_regs
  import hbi_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NIB   = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic              wr_cmd,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              rd_clr,
  input  logic              loc_in_rd,
  input  logic              loc_out_ld,
  input  logic [DATA_W-1:0] loc_out_data,
  input  logic              loc_sts_ld,
  input  logic [NIB-1:0]    loc_sts_nib,
  input  logic              loc_f0_tgl,
  input  logic              loc_flag_en,
  output logic [DATA_W-1:0] in_buf,
  output logic [DATA_W-1:0] out_buf,
  output logic [NIB-1:0]    usr_nib,
  output hbi_flags_t        flags,
  output logic              flag_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_buf    <= '0;
      out_buf   <= '0;
      usr_nib   <= '0;
      flags     <= '0;
      flag_mode <= 1'b0;
    end else begin
      if (wr_evt) begin
        in_buf    <= wr_byte;
        flags.cmd <= wr_cmd;
      end
      // Set beats clear on both mailboxes.
      if (wr_evt)          flags.in_full <= 1'b1;
      else if (loc_in_rd)  flags.in_full <= 1'b0;
      if (loc_out_ld) begin
        out_buf        <= loc_out_data;
        flags.out_full <= 1'b1;
      end else if (rd_clr) begin
        flags.out_full <= 1'b0;
      end
      if (loc_sts_ld)  usr_nib   <= loc_sts_nib;
      if (loc_f0_tgl)  flags.usr <= ~flags.usr;
      if (loc_flag_en) flag_mode <= 1'b1;
    end
  end
endmodule

// File: rtl/hbi_slave_port.sv
module hbi_slave_port
  import hbi_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_cs_n,
  input  logic              hst_rd_n,
  input  logic              hst_wr_n,
  input  logic              hst_a0,
  input  logic [DATA_W-1:0] hst_din,
  output logic [DATA_W-1:0] hst_dout,
  output logic              hst_dout_oe,
  input  logic              loc_in_rd,
  output logic [DATA_W-1:0] loc_in_data,
  input  logic              loc_out_ld,
  input  logic [DATA_W-1:0] loc_out_data,
  input  logic              loc_sts_ld,
  input  logic [DATA_W/2-1:0] loc_sts_nib,
  input  logic              loc_f0_tgl,
  input  logic              loc_flag_en,
  input  logic [1:0]        loc_pin_latch,
  output logic [DATA_W-1:0] status,
  output logic [1:0]        irq_pins
);
  localparam int NIB = DATA_W / 2;
  localparam int QW  = DATA_W + 2;   // data, address bit, chip select

  // Strobes: {rd_n, wr_n}, synchronized, then one extra register for edges.
  logic [1:0]    strb_now, strb_prev;
  // Qualifiers ride one stage longer so they line up with strb_prev.
  logic [QW-1:0] qual_d;

  hbi_strobe_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_strb (
    .clk(clk), .rst_n(rst_n), .d_in({hst_rd_n, hst_wr_n}), .q(strb_now));

  hbi_strobe_sync #(.W(QW), .STAGES(SYNC_STAGES+1), .RST_VAL({QW{1'b1}})) u_qual (
    .clk(clk), .rst_n(rst_n), .d_in({hst_din, hst_a0, hst_cs_n}), .q(qual_d));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_prev <= 2'b11;
    else        strb_prev <= strb_now;
  end

  // Named event wires, observed by the checker.
  logic wr_evt, rd_evt, wr_cmd, rd_clr, flag_mode;
  logic [DATA_W-1:0] wr_byte;

  assign wr_evt  = strb_now[0] & ~strb_prev[0] & ~qual_d[0];
  assign rd_evt  = strb_now[1] & ~strb_prev[1] & ~qual_d[0];
  assign wr_cmd  = qual_d[1];
  assign wr_byte = qual_d[QW-1:2];
  assign rd_clr  = rd_evt & ~qual_d[1];

  logic [DATA_W-1:0] in_buf, out_buf;
  logic [NIB-1:0]    usr_nib;
  hbi_flags_t        flags;

  hbi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_evt(wr_evt), .wr_cmd(wr_cmd), .wr_byte(wr_byte), .rd_clr(rd_clr),
    .loc_in_rd(loc_in_rd), .loc_out_ld(loc_out_ld), .loc_out_data(loc_out_data),
    .loc_sts_ld(loc_sts_ld), .loc_sts_nib(loc_sts_nib),
    .loc_f0_tgl(loc_f0_tgl), .loc_flag_en(loc_flag_en),
    .in_buf(in_buf), .out_buf(out_buf), .usr_nib(usr_nib),
    .flags(flags), .flag_mode(flag_mode));

  assign status      = {usr_nib, flags};
  assign loc_in_data = in_buf;
  assign hst_dout_oe = ~hst_cs_n & ~hst_rd_n;
  assign hst_dout    = hbi_read_mux(hst_a0, status, out_buf);
  assign irq_pins    = hbi_pin_out(flag_mode, loc_pin_latch, flags.in_full, flags.out_full);
endmodule

// File: rtl/hbi_slave_port_chk.sv
module hbi_slave_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hst_cs_n,
  input logic              hst_dout_oe,
  input logic [DATA_W-1:0] status,
  input logic              loc_sts_ld,
  input logic [DATA_W/2-1:0] loc_sts_nib,
  input logic              loc_out_ld,
  input logic              loc_in_rd,
  input logic              wr_evt,
  input logic              rd_evt,
  input logic              wr_cmd,
  input logic              rd_clr,
  input logic              flag_mode,
  input logic [1:0]        irq_pins,
  input logic [1:0]        loc_pin_latch
);
  localparam int NIB = DATA_W / 2;

  a_r2_in_full_set: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> status[1]);
  a_r3_cmd_marker: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> status[3] == $past(wr_cmd));
  a_r4_out_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !loc_out_ld) |=> !status[0]);
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_evt && !rd_evt && !loc_in_rd && !loc_out_ld) |=> $stable(status[1:0]));
  a_r6_out_set: assert property (@(posedge clk) disable iff (!rst_n)
    loc_out_ld |=> status[0]);
  a_r6_in_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_in_rd && !wr_evt) |=> !status[1]);
  a_r7_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    loc_sts_ld |=> status[DATA_W-1 -: NIB] == $past(loc_sts_nib));
  a_r9_port_mode: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_mode |-> irq_pins == loc_pin_latch);
  a_r9_flag_mode: assert property (@(posedge clk) disable iff (!rst_n)
    flag_mode |-> (irq_pins[0] == (loc_pin_latch[0] && status[0])) &&
                  (irq_pins[1] == (loc_pin_latch[1] && !status[1])));
  a_r10_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    hst_cs_n |-> !hst_dout_oe);
endmodule

bind hbi_slave_port hbi_slave_port_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_hbi_slave_port.sv
module tb_hbi_slave_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hst_cs_n = 1'b1, hst_rd_n = 1'b1, hst_wr_n = 1'b1, hst_a0 = 1'b0;
  logic [7:0] hst_din = '0;
  logic [7:0] hst_dout;
  logic       hst_dout_oe;
  logic       loc_in_rd = 0, loc_out_ld = 0, loc_sts_ld = 0, loc_f0_tgl = 0, loc_flag_en = 0;
  logic [7:0] loc_in_data, loc_out_data = '0;
  logic [3:0] loc_sts_nib = '0;
  logic [1:0] loc_pin_latch = 2'b10;
  logic [7:0] status;
  logic [1:0] irq_pins;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hbi_slave_port dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic cs, input logic a0, input logic [7:0] d);
    @(negedge clk); hst_cs_n = cs; hst_a0 = a0; hst_din = d; hst_wr_n = 0;
    repeat (3) @(negedge clk);
    hst_wr_n = 1;
    repeat (4) @(negedge clk);
    hst_cs_n = 1;
  endtask

  task automatic host_read(input logic cs, input logic a0, output logic [7:0] d, output logic oe);
    @(negedge clk); hst_cs_n = cs; hst_a0 = a0; hst_rd_n = 0;
    repeat (3) @(negedge clk);
    d = hst_dout; oe = hst_dout_oe;
    hst_rd_n = 1;
    repeat (4) @(negedge clk);
    hst_cs_n = 1;
  endtask

  task automatic pulse(input int which, input logic [7:0] d);
    @(negedge clk);
    case (which)
      2: loc_in_rd = 1;
      3: begin loc_out_data = d; loc_out_ld = 1; end
      4: begin loc_sts_nib = d[7:4]; loc_sts_ld = 1; end
      5: loc_f0_tgl = 1;
      default: loc_flag_en = 1;
    endcase
    @(negedge clk);
    {loc_in_rd, loc_out_ld, loc_sts_ld, loc_f0_tgl, loc_flag_en} = '0;
  endtask

  // {op, a0, data, expected status, expected read byte, requirement}
  // op: 0 host write, 1 host read, 2 local drain, 3 local load, 4 status load, 5 toggle
  localparam logic [35:0] VEC [12] = '{
    36'h3_0_A5_01_00_6,  // R6 load outbound
    36'h1_1_00_01_01_4,  // R4 status read, no flag change
    36'h1_0_00_00_A5_4,  // R4 data read clears outbound-full
    36'h0_0_3C_02_00_2,  // R2 data write
    36'h2_0_00_00_3C_6,  // R6 drain shows byte, clears inbound-full
    36'h0_1_C3_0A_00_3,  // R3 command write
    36'h4_0_9F_9A_00_7,  // R7 upper nibble only
    36'h5_0_00_9E_00_8,  // R8 toggle on
    36'h2_0_00_9C_C3_6,  // R6 drain command byte
    36'h0_0_11_96_00_2,  // R2 data write clears command marker
    36'h5_0_00_92_00_8,  // R8 toggle off
    36'h1_1_00_92_92_4   // R4 status read
  };

  initial begin
    logic [7:0] rd;
    logic       oe;
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(status == 8'h00, "R1 status", status, 0);
    chk(irq_pins == 2'b10, "R1 pins", irq_pins, 2);
    chk(hst_dout_oe == 0, "R1 oe", hst_dout_oe, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [35:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[3:0], i);
      case (v[35:32])
        0: host_write(1'b0, v[28], v[27:20]);
        1: begin
          host_read(1'b0, v[28], rd, oe);
          chk(rd == v[11:4], tag, rd, v[11:4]);
          chk(oe == 1'b1, {tag, " oe"}, oe, 1);
        end
        2: begin
          chk(loc_in_data == v[11:4], tag, loc_in_data, v[11:4]);
          pulse(2, 0);
        end
        default: pulse(int'(v[35:32]), v[27:20]);
      endcase
      @(negedge clk);
      chk(status == v[19:12], {tag, " status"}, status, v[19:12]);
    end

    // R5: nothing moves while the write strobe is low or just released
    @(negedge clk); hst_cs_n = 0; hst_a0 = 1; hst_din = 8'h55; hst_wr_n = 0;
    repeat (3) @(negedge clk);
    chk(status == 8'h92, "R5 strobe low", status, 8'h92);
    hst_wr_n = 1;
    @(negedge clk);
    chk(status == 8'h92, "R5 edge in sync", status, 8'h92);
    repeat (3) @(negedge clk);
    chk(status == 8'h9A, "R5 after edge", status, 8'h9A);
    hst_cs_n = 1;

    // R10: deselected strobes ignored, bus not driven
    host_write(1'b1, 1'b0, 8'h77);
    @(negedge clk);
    chk(status == 8'h9A, "R10 status", status, 8'h9A);
    chk(loc_in_data == 8'h55, "R10 inbound byte", loc_in_data, 8'h55);
    host_read(1'b1, 1'b0, rd, oe);
    chk(oe == 1'b0, "R10 oe", oe, 0);

    // R11: drain in the same cycle as the write event, inbound-full stays set
    @(negedge clk); hst_cs_n = 0; hst_a0 = 0; hst_din = 8'h66; hst_wr_n = 0;
    repeat (3) @(negedge clk);
    hst_wr_n = 1;
    repeat (2) @(negedge clk);
    loc_in_rd = 1;
    @(negedge clk);
    loc_in_rd = 0;
    hst_cs_n = 1;
    @(negedge clk);
    chk(status[1] == 1'b1, "R11 inbound-full", status[1], 1);
    chk(loc_in_data == 8'h66, "R11 byte", loc_in_data, 8'h66);
    chk(status == 8'h92, "R11 status", status, 8'h92);

    // R9: port mode then flag mode
    loc_pin_latch = 2'b01;
    @(negedge clk);
    chk(irq_pins == 2'b01, "R9 port mode", irq_pins, 1);
    pulse(6, 0);
    loc_pin_latch = 2'b11;
    @(negedge clk);
    chk(irq_pins == 2'b00, "R9 both busy", irq_pins, 0);
    pulse(2, 0);
    @(negedge clk);
    chk(irq_pins == 2'b10, "R9 inbound empty", irq_pins, 2);
    pulse(3, 8'h5A);
    @(negedge clk);
    chk(irq_pins == 2'b11, "R9 outbound full", irq_pins, 3);
    loc_pin_latch = 2'b00;
    @(negedge clk);
    chk(irq_pins == 2'b00, "R9 gated off", irq_pins, 0);

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule